// File: doc/BRIEF.md
# Register File with a Stack-Mapped Index

This block is a small general-purpose register file with two combinational read ports and one write port. One register index has no storage word behind it. Reads and writes to that index go to an internal last-in, first-out stack instead, so software can keep return addresses in a hardware stack by naming an ordinary register.

A write to the stack index pushes the write data. An enabled read of it returns the top entry and pops it at the next clock edge. Doing both in one instruction overwrites the top entry.

The execute stage raises a vector of error categories late in the cycle. When any category is set, every state update of that instruction is dropped. The error vector reaches only the update enables. The read-data multiplexers pick stack or storage from the register index alone, so the late error never lies on the read path.

Top module: `stackRegFile`

## Requirements
- R1: After the synchronous active-low reset, every register reads zero, the stack is empty, and both flags are low.
- R2: A write with `wrEn` high to an index other than 0 and 1 updates that register at the clock edge. Reads are combinational and return the stored word in the same cycle.
- R3: Index 0 always reads as zero, and writes to it have no effect.
- R4: A write to index 1 pushes `wrData`. A read of index 1 returns the current top entry, or zero when the stack is empty, whether or not the read is enabled.
- R5: An enabled read of index 1 pops one entry at the clock edge. When both ports read index 1 with their enables high, only one entry is popped, and both ports return the same top value.
- R6: An enabled read and a write of index 1 in the same cycle replace the top entry with `wrData`, and the depth is unchanged.
- R7: If any bit of `errVec` is high, that cycle's push, pop, replace, register write and flag raise are all dropped.
- R8: A push, with no pop, when all 8 entries are occupied leaves the stack unchanged and raises `overflow` high for exactly the following cycle.
- R9: A pop when the stack is empty, including a pop combined with a push, leaves the stack unchanged and raises `underflow` high for exactly the following cycle.
- R10: Read data on both ports is independent of `errVec`. With the same indices and state, the same values are returned.
- R11: The stack returns entries in last-in, first-out order across its full depth of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rdEnA | input | 1 | Port A read is used by the instruction (enables pop) |
| rdIdxA | input | 4 | Port A register index |
| rdDataA | output | 32 | Port A read data |
| rdEnB | input | 1 | Port B read is used by the instruction (enables pop) |
| rdIdxB | input | 4 | Port B register index |
| rdDataB | output | 32 | Port B read data |
| wrEn | input | 1 | Write request |
| wrIdx | input | 4 | Write register index |
| wrData | input | 32 | Write data |
| errVec | input | 4 | Late error categories; any set bit cancels the instruction |
| overflow | output | 1 | One-cycle pulse after a rejected push |
| underflow | output | 1 | One-cycle pulse after a rejected pop |

## Verification
The bench targets the corners where a wrong design would corrupt the stack quietly. Both ports popping the same index must remove only one entry; a design that popped twice would lose a return address. A read and write of the stack in one cycle must replace the top entry, and a design that pushed instead would grow the depth. A push into a full stack and a pop from an empty one, including the combined pop-and-push on an empty stack, must each pulse the correct flag and leave the contents intact.

Error cycles are driven with single and multiple category bits while pushes, pops and register writes are requested, and the bench then reads the state back to confirm nothing moved. The stack-index reads in those same error cycles show that read data is unaffected by the error vector.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic replace;
    logic regWr;
    logic ovfSet;
    logic unfSet;
  } srfStrobes_t;
endpackage

// File: rtl/srf_ctrl.sv
module srf_ctrl import srf_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int DEPTH    = 8,
  parameter int STK_IDX  = 1,
  parameter int NUM_ERR  = 4,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEnA,
  input  logic [AW-1:0]      rdIdxA,
  input  logic               rdEnB,
  input  logic [AW-1:0]      rdIdxB,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrIdx,
  input  logic [NUM_ERR-1:0] errVec,
  input  logic [CW-1:0]      stkCnt,
  output srfStrobes_t        strb
);
  localparam logic [AW-1:0] StkIdx = AW'(STK_IDX);

  logic popWant, pushWant, stkEmpty, stkFull, cancel;
  logic underRun, overRun, legal;

  // Intent: what the instruction asks for, decided from indices only
  assign popWant  = (rdEnA && rdIdxA == StkIdx) || (rdEnB && rdIdxB == StkIdx);
  assign pushWant = wrEn && (wrIdx == StkIdx);
  assign stkEmpty = (stkCnt == '0);
  assign stkFull  = (stkCnt == CW'(DEPTH));
  assign underRun = popWant && stkEmpty;
  assign overRun  = pushWant && !popWant && stkFull;
  assign legal    = !underRun && !overRun;

  // Late error: gates only the update enables
  assign cancel = |errVec;

  always_comb begin
    strb         = '0;
    strb.push    = !cancel && legal && pushWant && !popWant;
    strb.pop     = !cancel && legal && popWant && !pushWant;
    strb.replace = !cancel && legal && popWant && pushWant;
    strb.regWr   = !cancel && wrEn && wrIdx != StkIdx && wrIdx != '0;
    strb.ovfSet  = !cancel && overRun;
    strb.unfSet  = !cancel && underRun;
  end

  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.push, strb.pop, strb.replace}) <= 1); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stkEmpty |-> !(strb.pop || strb.replace)); // R9
endmodule

// File: rtl/srf_dp.sv
module srf_dp import srf_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int DEPTH    = 8,
  parameter int STK_IDX  = 1,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  srfStrobes_t       strb,
  input  logic [AW-1:0]     rdIdxA,
  input  logic [AW-1:0]     rdIdxB,
  input  logic [AW-1:0]     wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [CW-1:0]     stkCnt,
  output logic              ovfFlag,
  output logic              unfFlag
);
  localparam logic [AW-1:0] StkIdx = AW'(STK_IDX);

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] stkQ [DEPTH];
  logic [CW-1:0]     cntQ, cntM1;
  logic [DATA_W-1:0] topData;
  logic              selStkA, selStkB;

  // Register storage; index 0 is a constant zero
  assign regQ[0] = '0;
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                              regQ[i] <= '0;
      else if (strb.regWr && wrIdx == AW'(i)) regQ[i] <= wrData;
    end
  end

  // Stack entries: written on push at slot cnt, or on replace at slot cnt-1
  for (genvar j = 0; j < DEPTH; j++) begin : g_stk
    always_ff @(posedge clk) begin
      if (!rstN) stkQ[j] <= '0;
      else if ((strb.push && cntQ == CW'(j)) ||
               (strb.replace && cntQ == CW'(j + 1)))
        stkQ[j] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cntQ <= '0;
    else if (strb.push)    cntQ <= cntQ + 1'b1;
    else if (strb.pop)     cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      ovfFlag <= strb.ovfSet;
      unfFlag <= strb.unfSet;
    end
  end

  // Read path: the select depends on the index only
  assign cntM1   = cntQ - 1'b1;
  assign topData = (cntQ == '0) ? '0 : stkQ[cntM1[PW-1:0]];
  assign selStkA = (rdIdxA == StkIdx);
  assign selStkB = (rdIdxB == StkIdx);
  assign rdDataA = selStkA ? topData : regQ[rdIdxA];
  assign rdDataB = selStkB ? topData : regQ[rdIdxB];
  assign stkCnt  = cntQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CW'(DEPTH)); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> cntQ == $past(cntQ) + 1'b1); // R4
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> cntQ == $past(cntQ) - 1'b1); // R5
  AST_REPLACE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.replace |=> $stable(cntQ)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag)); // R9
endmodule

// File: rtl/stackRegFile.sv
module stackRegFile import srf_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int DEPTH    = 8,
  parameter int STK_IDX  = 1,
  parameter int NUM_ERR  = 4,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEnA,
  input  logic [AW-1:0]      rdIdxA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic               rdEnB,
  input  logic [AW-1:0]      rdIdxB,
  output logic [DATA_W-1:0]  rdDataB,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_ERR-1:0] errVec,
  output logic               overflow,
  output logic               underflow
);
  srfStrobes_t   strb;
  logic [CW-1:0] stkCnt;

  srf_ctrl #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH), .STK_IDX(STK_IDX),
             .NUM_ERR(NUM_ERR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEnA(rdEnA), .rdIdxA(rdIdxA),
    .rdEnB(rdEnB), .rdIdxB(rdIdxB), .wrEn(wrEn), .wrIdx(wrIdx),
    .errVec(errVec), .stkCnt(stkCnt), .strb(strb));

  srf_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .DEPTH(DEPTH),
           .STK_IDX(STK_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .wrIdx(wrIdx), .wrData(wrData), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .stkCnt(stkCnt), .ovfFlag(overflow), .unfFlag(underflow));

  AST_ERR_HOLDS_STACK: assert property (@(posedge clk) disable iff (!rstN)
    (|errVec) |=> $stable(stkCnt)); // R7
  AST_ERR_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (|errVec) |=> !overflow && !underflow); // R7
  AST_ZERO_IDX: assert property (@(posedge clk) disable iff (!rstN)
    rdIdxA == '0 |-> rdDataA == '0); // R3
endmodule

// File: tb/sim_stackRegFile.sv
`timescale 1ns/100ps
module sim_stackRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEnA = 0, rdEnB = 0, wrEn = 0;
  logic [3:0]  rdIdxA = 0, rdIdxB = 0, wrIdx = 0, errVec = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdDataA, rdDataB;
  logic        overflow, underflow;

  always #2.5 clk = ~clk;

  stackRegFile u0 (.clk(clk), .rstN(rstN), .rdEnA(rdEnA), .rdIdxA(rdIdxA),
    .rdDataA(rdDataA), .rdEnB(rdEnB), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .errVec(errVec),
    .overflow(overflow), .underflow(underflow));

  typedef struct {
    logic [31:0] expA;
    logic [31:0] expB;
    logic        expOvf;
    logic        expUnf;
    string       tag;
  } item_t;

  item_t       scoreQ[$];
  int          nRun = 0, nFail = 0;
  logic [31:0] mReg [16];
  logic [31:0] mStk [8];
  int          mCnt = 0;
  logic        mOvf = 0, mUnf = 0;
  bit          finished = 0;

  function automatic logic [31:0] mRead(input logic [3:0] idx);
    if (idx == 0) return 0;
    if (idx == 1) return (mCnt == 0) ? 32'h0 : mStk[mCnt-1];
    return mReg[idx];
  endfunction

  // Driver: one instruction per cycle, computes the expectation and updates the model
  task automatic op(input logic eA, input logic [3:0] iA, input logic eB,
                    input logic [3:0] iB, input logic we, input logic [3:0] wi,
                    input logic [31:0] wd, input logic [3:0] err, input string tag);
    item_t it;
    bit pw, pu, bad;
    @(negedge clk);
    rdEnA = eA; rdIdxA = iA; rdEnB = eB; rdIdxB = iB;
    wrEn = we; wrIdx = wi; wrData = wd; errVec = err;
    it.expA = mRead(iA); it.expB = mRead(iB);
    it.expOvf = mOvf; it.expUnf = mUnf; it.tag = tag;
    scoreQ.push_back(it);
    pw = (eA && iA == 1) || (eB && iB == 1);
    pu = we && wi == 1;
    bad = (err != 0);
    mOvf = 0; mUnf = 0;
    if (!bad) begin
      if (pw && mCnt == 0) mUnf = 1;
      else if (pu && !pw && mCnt == 8) mOvf = 1;
      else if (pu && pw) mStk[mCnt-1] = wd;
      else if (pu) begin mStk[mCnt] = wd; mCnt++; end
      else if (pw) mCnt--;
      if (we && wi > 1) mReg[wi] = wd;
    end
  endtask

  task automatic idle(input logic [3:0] iA, input logic [3:0] iB, input string tag);
    op(0, iA, 0, iB, 0, 0, 0, 0, tag);
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: samples before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (scoreQ.size() > 0) begin
        item_t it;
        it = scoreQ.pop_front();
        chk(it.tag, "rdDataA", rdDataA, it.expA);
        chk(it.tag, "rdDataB", rdDataB, it.expB);
        chk(it.tag, "overflow", {31'b0, overflow}, {31'b0, it.expOvf});
        chk(it.tag, "underflow", {31'b0, underflow}, {31'b0, it.expUnf});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) mReg[k] = 0;
    for (int k = 0; k < 8; k++) mStk[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    idle(1, 2, "R1 reset");
    idle(5, 15, "R1 reset");
    op(0, 0, 0, 0, 1, 2, 32'hAAAA_0002, 0, "R2 write");
    op(0, 2, 0, 3, 1, 3, 32'h3333_0003, 0, "R2 read");
    idle(2, 3, "R2 readback");
    op(0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF, 0, "R3 write zero");
    idle(0, 0, "R3 read zero");
    op(0, 1, 0, 0, 1, 1, 32'h1000_0001, 0, "R4 push");
    op(0, 1, 0, 1, 1, 1, 32'h1000_0002, 0, "R4 push");
    idle(1, 1, "R4 top");
    op(1, 1, 1, 1, 0, 0, 0, 0, "R5 dual pop");
    idle(1, 2, "R5 after dual pop");
    op(1, 1, 0, 0, 1, 1, 32'h2000_0009, 0, "R6 replace");
    idle(1, 1, "R6 after replace");
    op(1, 1, 0, 1, 0, 0, 0, 4'b0001, "R7 R10 pop cancelled");
    op(0, 1, 0, 2, 1, 1, 32'h5555_5555, 4'b0110, "R7 push cancelled");
    op(0, 2, 0, 1, 1, 2, 32'h6666_6666, 4'b1000, "R7 write cancelled");
    op(1, 1, 0, 0, 1, 1, 32'h7777_7777, 4'b1111, "R7 replace cancelled");
    idle(1, 2, "R7 state held");
    op(0, 1, 0, 0, 0, 0, 0, 0, "R11 settle");
    for (int k = 0; k < 7; k++)
      op(0, 1, 0, 0, 1, 1, 32'hC000_0000 + k, 0, "R11 fill");
    op(0, 1, 0, 0, 1, 1, 32'hBAD0_0000, 0, "R8 push full");
    idle(1, 1, "R8 overflow pulse");
    idle(1, 1, "R8 pulse cleared");
    op(0, 1, 0, 0, 1, 1, 32'hBAD0_0001, 4'b0100, "R7 R8 cancelled overflow");
    idle(1, 1, "R7 no flag");
    for (int k = 0; k < 8; k++)
      op(1, 1, 0, 1, 0, 0, 0, 0, "R11 drain");
    op(1, 1, 0, 0, 0, 0, 0, 0, "R9 pop empty");
    idle(1, 1, "R9 underflow pulse");
    op(1, 1, 0, 0, 1, 1, 32'hE000_0001, 0, "R9 pop push empty");
    idle(1, 1, "R9 second pulse");
    idle(1, 1, "R9 cleared");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 16; k++) mReg[k] = 0;
    mCnt = 0; mOvf = 0; mUnf = 0;
    idle(2, 3, "R1 re-reset");
    idle(1, 0, "R1 re-reset");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule